// File: doc/BRIEF.md
# Stereo Z Intercept Fitter

This block fits a straight line through the z measurements of a seed track that crosses six stereo layers. From this line it reports the z intercept on the beam axis (z0) and the dip slope. For each layer it takes the measured stereo angle and applies two curvature-dependent corrections. It then converts the corrected angle to a z value and adds it into two weighted sums. Only layers marked as hit take part in these sums. A closed-form least-squares solution combines the two sums with coefficients that depend on the hit pattern and the curvature index. The result is saturated into narrow signed fields.

Every coefficient sits in a small table that is filled through a write-only load port before fitting starts. The table address packs a layer or hit-pattern field together with the curvature index. The pipeline accepts one seed per clock. Each result appears a fixed number of cycles later, together with an error estimate looked up from the same tables and a copy of the hit pattern. A seed with too few hit layers cannot be fitted. For such a seed the block outputs a fixed failure code.

Top module: `stereo_zfit`

## Requirements
- R1: For layer l, the corrected angle is `ang[l] - in_dphi + ((K[l][rh] * in_drho) >>> 6)`. All quantities are signed, and `>>>` is a floor shift. `in_ang` holds layer l in bits `[12*l+11 : 12*l]`.
- R2: The z value of layer l is `(corrected angle * Rs[l]) >>> 8`.
- R3: Only layers whose `in_hit` bit is set contribute. S is the sum of `z * Wz[l]` and D is the sum of `z * Wd[l][rh]` over those layers.
- R4: When the fit succeeds, `out_z0` = sat(`(((S*Cdd) >>> 6) - ((D*Cd) >>> 6)) * Q >>> 16`). The three coefficients are indexed by {hit, rh}. sat clamps to the range [-127, 127], so -128 never appears on a successful fit.
- R5: When the fit succeeds, `out_slope` = sat(`(((D*C0[hit]) >>> 1) - ((S*Cd) >>> 1)) * Q >>> 16`), with the same clamp as R4.
- R6: When the fit succeeds, `out_zerr` is the 4-bit error table entry at {hit, rh}.
- R7: A seed with fewer than two hit bits set is a failed fit. It reports `out_fail`=1, `out_z0`=-128, `out_slope`=-128 and `out_zerr`=15. A seed with two or more hit bits set is never a failed fit.
- R8: `out_hit` returns the hit pattern of the same seed, unchanged.
- R9: `out_valid` is high in the fourth cycle after each cycle with `in_valid` high, and at no other time. One seed per cycle is accepted with no gaps.
- R10: Load port. When `ld_en`=1, `ld_data` is written to the table selected by `ld_sel`. The table codes are: 0=K, 1=Rs, 2=Wz, 3=Wd, 4=Cdd, 5=Cd, 6=C0, 7=Q, 8=error, where the error table keeps the low 4 bits of the data. `ld_addr[8:3]` holds the layer or the hit pattern, and `ld_addr[2:0]` holds rh. A per-layer write with a layer field of 6 or more changes nothing.
- R11: After reset, `out_valid`, `out_fail`, `out_z0`, `out_slope`, `out_zerr` and `out_hit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Table write strobe |
| ld_sel | input | 4 | Table select code |
| ld_addr | input | 9 | {layer or hit pattern, curvature index} |
| ld_data | input | 12 | Signed coefficient to write |
| in_valid | input | 1 | Seed present this cycle |
| in_ang | input | 72 | Six signed 12-bit stereo angles |
| in_dphi | input | 12 | Signed angle correction |
| in_drho | input | 12 | Signed curvature correction |
| in_rh | input | 3 | Curvature index |
| in_hit | input | 6 | Stereo-layer hit pattern |
| out_valid | output | 1 | Result present |
| out_z0 | output | 8 | Signed z intercept |
| out_slope | output | 8 | Signed dip slope |
| out_zerr | output | 4 | z0 error estimate |
| out_fail | output | 1 | Fit failed |
| out_hit | output | 6 | Hit pattern passed through |

## Verification
The hardest results to reach from the ports are saturated ones at both signs. These must occur close to in-range results and close to the two-hit boundary where a fit switches between failing and succeeding. With small coefficients most results stay in range, and with full-range coefficients almost every result clamps. The stimulus therefore loads a small-coefficient table set first and later reloads full-range coefficients. It sweeps all 64 hit patterns and sends back-to-back and gapped seeds. It also counts how often each clamp case occurred and requires every case to have been seen. Writes aimed at layer fields beyond the sixth layer are mixed in between fits so that any corruption would appear in the following results.

// File: rtl/zfit_pkg.sv
package zfit_pkg;
  typedef logic signed [63:0] wide_t;

  localparam int NLAYER = 6;
  localparam int RHW    = 3;
  localparam int HITW   = 6;

  typedef enum logic [3:0] {
    TB_KFAC = 4'd0, TB_RSTR = 4'd1, TB_WZ = 4'd2, TB_WD = 4'd3,
    TB_CDD  = 4'd4, TB_CD   = 4'd5, TB_C0 = 4'd6, TB_Q  = 4'd7,
    TB_ERR  = 4'd8
  } tbl_e;

  function automatic wide_t f_correct(wide_t ang, wide_t dang, wide_t kfac, wide_t dcurv);
    return ang - dang + ((kfac * dcurv) >>> 6);
  endfunction

  function automatic wide_t f_to_z(wide_t corr, wide_t rs);
    return (corr * rs) >>> 8;
  endfunction

  function automatic wide_t f_cross(wide_t a, wide_t ta, wide_t b, wide_t tb, int sh);
    return ((a * ta) >>> sh) - ((b * tb) >>> sh);
  endfunction

  function automatic wide_t f_solve(wide_t diff, wide_t q);
    return (diff * q) >>> 16;
  endfunction

  function automatic logic signed [7:0] f_sat8(wide_t v);
    if (v > 64'sd127) return 8'sd127;
    else if (v < -64'sd127) return -8'sd127;
    else return 8'(v);
  endfunction
endpackage

// File: rtl/zf_lut.sv
module zf_lut #(
  parameter int AW = 9,
  parameter int W  = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/zf_layer.sv
module zf_layer
  import zfit_pkg::*;
#(
  parameter int ANG_W  = 12,
  parameter int CORR_W = 12,
  parameter int TW     = 12,
  parameter int LIDX   = 0
) (
  input  logic                    clk,
  input  logic                    ld_en,
  input  logic [3:0]              ld_sel,
  input  logic [HITW+RHW-1:0]     ld_addr,
  input  logic signed [TW-1:0]    ld_data,
  input  logic signed [ANG_W-1:0] ang,
  input  logic signed [CORR_W-1:0] dphi,
  input  logic signed [CORR_W-1:0] drho,
  input  logic [RHW-1:0]          rh,
  input  logic                    hit,
  output wide_t                   term_s,
  output wide_t                   term_d
);
  localparam int NRH = 1 << RHW;

  logic signed [TW-1:0] kfac_q [NRH];
  logic signed [TW-1:0] wd_q   [NRH];
  logic signed [TW-1:0] rs_q;
  logic signed [TW-1:0] wz_q;

  wire             mine   = (ld_addr[HITW+RHW-1:RHW] == HITW'(LIDX));
  wire [RHW-1:0]   ld_rh  = ld_addr[RHW-1:0];

  always_ff @(posedge clk) begin
    if (ld_en && mine) begin
      if (ld_sel == TB_KFAC) kfac_q[ld_rh] <= ld_data;
      if (ld_sel == TB_WD)   wd_q[ld_rh]   <= ld_data;
      if (ld_sel == TB_RSTR) rs_q          <= ld_data;
      if (ld_sel == TB_WZ)   wz_q          <= ld_data;
    end
  end

  wide_t corr, zval;
  always_comb begin
    corr   = f_correct(wide_t'(ang), wide_t'(dphi), wide_t'(kfac_q[rh]), wide_t'(drho));
    zval   = f_to_z(corr, wide_t'(rs_q));
    term_s = hit ? zval * wide_t'(wz_q)   : '0;
    term_d = hit ? zval * wide_t'(wd_q[rh]) : '0;
  end
endmodule

// File: rtl/stereo_zfit.sv
module stereo_zfit
  import zfit_pkg::*;
#(
  parameter int ANG_W  = 12,
  parameter int CORR_W = 12,
  parameter int TW     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [3:0]               ld_sel,
  input  logic [8:0]               ld_addr,
  input  logic [TW-1:0]            ld_data,
  input  logic                     in_valid,
  input  logic [6*ANG_W-1:0]       in_ang,
  input  logic [CORR_W-1:0]        in_dphi,
  input  logic [CORR_W-1:0]        in_drho,
  input  logic [2:0]               in_rh,
  input  logic [5:0]               in_hit,
  output logic                     out_valid,
  output logic [7:0]               out_z0,
  output logic [7:0]               out_slope,
  output logic [3:0]               out_zerr,
  output logic                     out_fail,
  output logic [5:0]               out_hit
);
  localparam int HAW = HITW + RHW;

  // stage 1: per-layer weighted terms
  wide_t lay_s [NLAYER];
  wide_t lay_d [NLAYER];
  wide_t s1_s  [NLAYER];
  wide_t s1_d  [NLAYER];
  logic [HITW-1:0] s1_hit;
  logic [RHW-1:0]  s1_rh;
  logic            s1_valid;

  for (genvar l = 0; l < NLAYER; l++) begin : g_layer
    zf_layer #(.ANG_W(ANG_W), .CORR_W(CORR_W), .TW(TW), .LIDX(l)) u_layer (
      .clk(clk), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
      .ld_data(ld_data), .ang(in_ang[l*ANG_W +: ANG_W]),
      .dphi(in_dphi), .drho(in_drho), .rh(in_rh), .hit(in_hit[l]),
      .term_s(lay_s[l]), .term_d(lay_d[l]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0; s1_hit <= '0; s1_rh <= '0;
      for (int l = 0; l < NLAYER; l++) begin s1_s[l] <= '0; s1_d[l] <= '0; end
    end else begin
      s1_valid <= in_valid; s1_hit <= in_hit; s1_rh <= in_rh;
      for (int l = 0; l < NLAYER; l++) begin s1_s[l] <= lay_s[l]; s1_d[l] <= lay_d[l]; end
    end
  end

  // stage 2: the two weighted sums
  wide_t sum_s, sum_d, s2_s, s2_d;
  logic [HITW-1:0] s2_hit;
  logic [RHW-1:0]  s2_rh;
  logic            s2_valid;

  always_comb begin
    sum_s = '0; sum_d = '0;
    for (int l = 0; l < NLAYER; l++) begin sum_s += s1_s[l]; sum_d += s1_d[l]; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0; s2_hit <= '0; s2_rh <= '0; s2_s <= '0; s2_d <= '0;
    end else begin
      s2_valid <= s1_valid; s2_hit <= s1_hit; s2_rh <= s1_rh; s2_s <= sum_s; s2_d <= sum_d;
    end
  end

  // stage 3: hit-pattern coefficient lookup and cross products
  logic [TW-1:0] hrd [3];
  logic [TW-1:0] c0_rd;
  logic [3:0]    err_rd;
  wire [HAW-1:0] hidx = {s2_hit, s2_rh};

  function automatic tbl_e hsel(int g);
    return (g == 0) ? TB_CDD : (g == 1) ? TB_CD : TB_Q;
  endfunction

  for (genvar g = 0; g < 3; g++) begin : g_htab
    zf_lut #(.AW(HAW), .W(TW)) u_tab (
      .clk(clk), .we(ld_en && ld_sel == hsel(g)), .waddr(ld_addr),
      .wdata(ld_data), .raddr(hidx), .rdata(hrd[g]));
  end

  zf_lut #(.AW(HITW), .W(TW)) u_c0 (
    .clk(clk), .we(ld_en && ld_sel == TB_C0), .waddr(ld_addr[HAW-1:RHW]),
    .wdata(ld_data), .raddr(s2_hit), .rdata(c0_rd));

  zf_lut #(.AW(HAW), .W(4)) u_err (
    .clk(clk), .we(ld_en && ld_sel == TB_ERR), .waddr(ld_addr),
    .wdata(ld_data[3:0]), .raddr(hidx), .rdata(err_rd));

  wire fit_fail_evt = ($countones(s2_hit) < 2);

  wide_t s3_zdiff, s3_tdiff, s3_q;
  logic [3:0]      s3_err;
  logic            s3_fail, s3_valid;
  logic [HITW-1:0] s3_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_zdiff <= '0; s3_tdiff <= '0; s3_q <= '0; s3_err <= '0;
      s3_fail <= 1'b0; s3_valid <= 1'b0; s3_hit <= '0;
    end else begin
      s3_zdiff <= f_cross(s2_s, wide_t'($signed(hrd[0])), s2_d, wide_t'($signed(hrd[1])), 6);
      s3_tdiff <= f_cross(s2_d, wide_t'($signed(c0_rd)), s2_s, wide_t'($signed(hrd[1])), 1);
      s3_q     <= wide_t'($signed(hrd[2]));
      s3_err   <= err_rd;
      s3_fail  <= fit_fail_evt;
      s3_valid <= s2_valid;
      s3_hit   <= s2_hit;
    end
  end

  // stage 4: solve, saturate, apply failure code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_z0 <= '0; out_slope <= '0;
      out_zerr <= '0; out_fail <= 1'b0; out_hit <= '0;
    end else begin
      out_valid <= s3_valid;
      out_hit   <= s3_hit;
      out_fail  <= s3_fail;
      out_z0    <= s3_fail ? 8'h80 : f_sat8(f_solve(s3_zdiff, s3_q));
      out_slope <= s3_fail ? 8'h80 : f_sat8(f_solve(s3_tdiff, s3_q));
      out_zerr  <= s3_fail ? 4'hF : s3_err;
    end
  end
endmodule

// File: rtl/zf_chk.sv
module zf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [5:0] in_hit,
  input logic       out_valid,
  input logic [7:0] out_z0,
  input logic [7:0] out_slope,
  input logic [3:0] out_zerr,
  input logic       out_fail,
  input logic [5:0] out_hit
);
  // R9
  lat_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 out_valid);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4));
  // R8
  hit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_hit == $past(in_hit, 4));
  // R7
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fail) |-> (out_z0 == 8'h80 && out_slope == 8'h80 && out_zerr == 4'hF));
  // R7
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fail == ($countones(out_hit) < 2)));
  // R4
  z0_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fail) |-> out_z0 != 8'h80);
  // R5
  slope_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fail) |-> out_slope != 8'h80);
endmodule

bind stereo_zfit zf_chk u_zf_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hit(in_hit),
  .out_valid(out_valid), .out_z0(out_z0), .out_slope(out_slope),
  .out_zerr(out_zerr), .out_fail(out_fail), .out_hit(out_hit));

// File: tb/tb_stereo_zfit.sv
module tb_stereo_zfit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_sel = '0;
  logic [8:0]  ld_addr = '0;
  logic [11:0] ld_data = '0;
  logic        in_valid = 1'b0;
  logic [71:0] in_ang = '0;
  logic [11:0] in_dphi = '0, in_drho = '0;
  logic [2:0]  in_rh = '0;
  logic [5:0]  in_hit = '0;
  logic        out_valid, out_fail;
  logic [7:0]  out_z0, out_slope;
  logic [3:0]  out_zerr;
  logic [5:0]  out_hit;

  stereo_zfit dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit chk_on = 0;
  bit done = 0;

  // bench mirror of the coefficient tables
  longint kf [6][8], wd [6][8], rs [6], wz [6];
  longint cdd [512], cd [512], qq [512], c0 [64];
  int     er [512];

  int z0_hi = 0, z0_lo = 0, z0_in = 0, sl_hi = 0, sl_lo = 0, nfail = 0;

  typedef struct { bit v; int z0; int sl; int er; int fl; int hit; } exp_t;
  exp_t q[$];

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(longint v, output int side);
    side = 0;
    if (v > 127) begin side = 1; return 127; end
    if (v < -127) begin side = -1; return -127; end
    return int'(v);
  endfunction

  function automatic exp_t model();
    exp_t e;
    longint s = 0, d = 0, c, z, zd, td;
    int nh = 0, rh, hit, idx, sd_z, sd_t;
    rh = int'(in_rh); hit = int'(in_hit);
    e.v = 1; e.hit = hit;
    for (int l = 0; l < 6; l++) if (hit[l]) nh++;
    if (nh < 2) begin
      e.z0 = -128; e.sl = -128; e.er = 15; e.fl = 1; nfail++;
      return e;
    end
    for (int l = 0; l < 6; l++) begin
      if (hit[l]) begin
        c = longint'($signed(in_ang[l*12 +: 12])) - longint'($signed(in_dphi))
            + ((kf[l][rh] * longint'($signed(in_drho))) >>> 6);
        z = (c * rs[l]) >>> 8;
        s += z * wz[l];
        d += z * wd[l][rh];
      end
    end
    idx = hit * 8 + rh;
    zd = ((s * cdd[idx]) >>> 6) - ((d * cd[idx]) >>> 6);
    td = ((d * c0[hit]) >>> 1) - ((s * cd[idx]) >>> 1);
    e.z0 = sat((zd * qq[idx]) >>> 16, sd_z);
    e.sl = sat((td * qq[idx]) >>> 16, sd_t);
    if (sd_z > 0) z0_hi++; else if (sd_z < 0) z0_lo++; else z0_in++;
    if (sd_t > 0) sl_hi++; else if (sd_t < 0) sl_lo++;
    e.er = er[idx]; e.fl = 0;
    return e;
  endfunction

  // reference compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      exp_t e, x;
      if (in_valid) e = model();
      else begin e.v = 0; e.z0 = 0; e.sl = 0; e.er = 0; e.fl = 0; e.hit = 0; end
      q.push_back(e);
      if (q.size() > 4) begin
        x = q.pop_front();
        chk("R9", "out_valid", int'(out_valid), int'(x.v));
        if (x.v) begin
          chk(x.fl ? "R7" : "R4", "out_z0", int'($signed(out_z0)), x.z0);
          chk(x.fl ? "R7" : "R5", "out_slope", int'($signed(out_slope)), x.sl);
          chk(x.fl ? "R7" : "R6", "out_zerr", int'(out_zerr), x.er);
          chk("R7", "out_fail", int'(out_fail), x.fl);
          chk("R8", "out_hit", int'(out_hit), x.hit);
        end
      end
    end
  end

  function automatic int rv(int m);
    return int'($urandom_range(0, 2 * m)) - m;
  endfunction

  task automatic ld(int sel, int addr, int v);
    int lay = addr >> 3, r = addr & 7;
    @(posedge clk); #2;
    ld_en = 1'b1; ld_sel = 4'(sel); ld_addr = 9'(addr); ld_data = 12'(v);
    case (sel)
      0: if (lay < 6) kf[lay][r] = v;
      1: if (lay < 6) rs[lay] = v;
      2: if (lay < 6) wz[lay] = v;
      3: if (lay < 6) wd[lay][r] = v;
      4: cdd[addr] = v;
      5: cd[addr] = v;
      6: c0[lay] = v;
      7: qq[addr] = v;
      8: er[addr] = v & 15;
      default: ;
    endcase
  endtask

  task automatic ld_stop();
    @(posedge clk); #2; ld_en = 1'b0;
  endtask

  // R10: fill every table; small coefficients keep results mostly in range
  task automatic load_all(bit big);
    int m = big ? 2047 : 16;
    for (int l = 0; l < 6; l++) begin
      ld(1, l * 8, big ? rv(2047) : rv(64));
      ld(2, l * 8, rv(m));
      for (int r = 0; r < 8; r++) begin
        ld(0, l * 8 + r, big ? rv(2047) : rv(64));
        ld(3, l * 8 + r, rv(m));
      end
    end
    for (int a = 0; a < 512; a++) begin
      ld(4, a, rv(m)); ld(5, a, rv(m)); ld(7, a, rv(m));
      ld(8, a, int'($urandom_range(0, 15)));
    end
    for (int h = 0; h < 64; h++) ld(6, h * 8, rv(m));
    ld_stop();
  endtask

  task automatic seed(bit v, int hit, int rh);
    @(posedge clk); #2;
    in_valid = v;
    for (int l = 0; l < 6; l++) in_ang[l*12 +: 12] = 12'(rv(2047));
    in_dphi = 12'(rv(2047)); in_drho = 12'(rv(2047));
    in_rh = 3'(rh); in_hit = 6'(hit);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) seed(1'b0, 0, 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state at the ports
    chk("R11", "out_valid", int'(out_valid), 0);
    chk("R11", "out_fail",  int'(out_fail), 0);
    chk("R11", "out_z0",    int'(out_z0), 0);
    chk("R11", "out_slope", int'(out_slope), 0);
    chk("R11", "out_zerr",  int'(out_zerr), 0);
    chk("R11", "out_hit",   int'(out_hit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1;

    load_all(1'b0);
    // R3 R6 R7: sweep every hit pattern, curvature index rotating
    for (int h = 0; h < 64; h++) seed(1'b1, h, h % 8);
    // R7 boundary: none, one and two layers hit
    seed(1'b1, 6'h00, 2); seed(1'b1, 6'h20, 5); seed(1'b1, 6'h21, 5); seed(1'b1, 6'h3F, 7);
    // R1 R2 R9: back-to-back and gapped random seeds
    for (int i = 0; i < 300; i++)
      seed($urandom_range(0, 3) != 0, int'($urandom_range(0, 63)), int'($urandom_range(0, 7)));
    idle(6);
    // R10: writes with layer fields 6, 7 and 63 must leave every table intact
    for (int sel = 0; sel < 4; sel++)
      foreach (kf[0][r]) begin
        ld(sel, 6 * 8 + r, 12'h7FF);
        ld(sel, 7 * 8 + r, -2048);
        ld(sel, 63 * 8 + r, 1234);
      end
    ld_stop();
    for (int i = 0; i < 64; i++) seed(1'b1, 6'h3F, i % 8);
    idle(6);

    // R4 R5: full-range coefficients drive both clamp directions
    load_all(1'b1);
    for (int i = 0; i < 250; i++)
      seed(1'b1, int'($urandom_range(0, 63)), int'($urandom_range(0, 7)));
    idle(8);

    chk("R4", "z0 clamped high seen", int'(z0_hi > 0), 1);
    chk("R4", "z0 clamped low seen",  int'(z0_lo > 0), 1);
    chk("R4", "z0 in range seen",     int'(z0_in > 0), 1);
    chk("R5", "slope clamped high seen", int'(sl_hi > 0), 1);
    chk("R5", "slope clamped low seen",  int'(sl_lo > 0), 1);
    chk("R7", "failed fits seen",     int'(nfail > 0), 1);
    done = 1;
    summary();
    $finish;
  end
endmodule